// File: doc/BRIEF.md
# Single-Precision Floating-Point Divider

This block divides one single-precision binary floating-point operand by another and returns the packed single-precision quotient. A caller presents both 32-bit operands with a one-cycle start pulse. Some time later the block raises done for one cycle, and the result is valid from that cycle onward. Operands that decide the answer on their own (NaN, zero, infinity) skip the arithmetic. All other operands go through three steps:

- The dividend significand is left-normalised, one bit per cycle.
- A radix-16 digit-recurrence core produces the quotient significand four bits per cycle. In each step the core subtracts every multiple of the divisor from the partial remainder in parallel, and a priority pick keeps the largest multiple that fits.
- A packing step normalises the quotient, forms the exponent and assembles the output word.

The controller has four states:

- `S_IDLE` waits for start. With start and special operands it moves to `S_PACK`. With start and ordinary operands it moves to `S_NORM`. Otherwise it stays in `S_IDLE`.
- `S_NORM` shifts the dividend significand left while its top bit is 0. Once the top bit is 1, it loads the core and moves to `S_DIV`.
- `S_DIV` stays put until the core reports its final digit, then moves to `S_PACK`.
- `S_PACK` registers the packed result, raises done, and always returns to `S_IDLE`.

Top module: `fp_div_sp`

## Requirements
- R1: An operand is decoded as sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0; for two normal operands with an in-range quotient the result carries that encoding (for example 0x40C00000 / 0x40000000 gives 0x40400000).
- R2: The result sign is the XOR of the operand signs, for ordinary and special results alike (except NaN, which is always positive).
- R3: The result biased exponent is dividend exponent minus divisor exponent plus 127, lowered by one when the dividend significand is smaller than the divisor significand (0x3F800000 / 0x3FC00000 gives 0x3F2AAAAA).
- R4: A dividend with exponent field 0 has hidden bit 0 and effective exponent −126; its significand is shifted left one bit per cycle until bit 23 is set, with the exponent decremented on each shift, and each shift adds one cycle of latency.
- R5: A divisor with exponent field 0 is used with hidden bit 0 and effective exponent −126 without being normalised (0x3F800000 / 0x00400000 gives 0x7F000000).
- R6: The quotient fraction is truncated toward zero (0x3F800000 / 0x40400000 gives 0x3EAAAAAA).
- R7: A computed biased exponent of 255 or more gives infinity with the result sign (exponent 0xFF, fraction 0).
- R8: A computed biased exponent of 0 or less gives zero with the result sign; the block never outputs a subnormal.
- R9: A NaN operand, 0/0 or ∞/∞ gives the quiet NaN 0x7FC00000.
- R10: A non-NaN, non-zero dividend over a zero divisor, or an infinite dividend over a finite divisor, gives signed infinity.
- R11: A zero dividend over a non-zero, non-NaN divisor, or a finite dividend over an infinite divisor, gives signed zero.
- R12: Done is high for exactly one cycle. It rises on the 15th rising edge counted from the edge that samples start for operands needing no dividend shift, one edge later for each shift, and on the 2nd edge for special operands.
- R13: A start pulse while an operation is in progress is ignored, and the running operation completes with its own result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; sampled only when idle |
| op_a | input | 32 | Dividend, single-precision |
| op_b | input | 32 | Divisor, single-precision |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | 32 | Packed single-precision quotient, held until the next done |

## Verification
The assertions assume start is a clean synchronous level that is low during reset. They also assume that operand values matter only in the cycle start is sampled, so the properties never reason about op_a or op_b at other times. The bench drives start and the operands only on falling edges. It holds the operands steady for the sampling edge and waits for done before issuing the next request, except in the one scenario that deliberately pulses start while the block is busy.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

    localparam int FRAC_W  = 23;
    localparam int EXP_W   = 8;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int EXT_W   = SIG_W;
    localparam int RADIX_W = 4;
    localparam int Q_W     = SIG_W + EXT_W;
    localparam int EXPI_W  = EXP_W + 3;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;

    localparam logic signed [EXPI_W-1:0] BIAS_S    = EXPI_W'(127);
    localparam logic signed [EXPI_W-1:0] EXP_TOP_S = EXPI_W'(255);
    localparam logic [WORD_W-1:0]        QNAN_W    = 32'h7FC0_0000;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_NORM = 2'd1,
        S_DIV  = 2'd2,
        S_PACK = 2'd3
    } fsm_t;

endpackage

// File: rtl/fpdiv_unpack.sv
module fpdiv_unpack
    import fpdiv_pkg::*;
(
    input  logic [WORD_W-1:0]        a,
    input  logic [WORD_W-1:0]        b,
    output logic                     sign,
    output logic signed [EXPI_W-1:0] exp_a,
    output logic signed [EXPI_W-1:0] exp_b,
    output logic [SIG_W-1:0]         sig_a,
    output logic [SIG_W-1:0]         sig_b,
    output logic                     special,
    output logic [WORD_W-1:0]        special_word
);

    logic [EXP_W-1:0]  ea_f, eb_f;
    logic [FRAC_W-1:0] fa_f, fb_f;
    logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, a_den, b_den;

    assign ea_f = a[WORD_W-2 -: EXP_W];
    assign eb_f = b[WORD_W-2 -: EXP_W];
    assign fa_f = a[FRAC_W-1:0];
    assign fb_f = b[FRAC_W-1:0];
    assign sign = a[WORD_W-1] ^ b[WORD_W-1];

    assign a_den  = (ea_f == '0);
    assign b_den  = (eb_f == '0);
    assign a_nan  = (ea_f == '1) && (fa_f != '0);
    assign b_nan  = (eb_f == '1) && (fb_f != '0);
    assign a_inf  = (ea_f == '1) && (fa_f == '0);
    assign b_inf  = (eb_f == '1) && (fb_f == '0);
    assign a_zero = a_den && (fa_f == '0);
    assign b_zero = b_den && (fb_f == '0);

    // subnormal: hidden bit 0, exponent behaves like biased value 1
    assign exp_a = a_den ? EXPI_W'(1) : $signed(EXPI_W'(ea_f));
    assign exp_b = b_den ? EXPI_W'(1) : $signed(EXPI_W'(eb_f));
    assign sig_a = {~a_den, fa_f};
    assign sig_b = {~b_den, fb_f};

    always_comb begin
        special      = 1'b1;
        special_word = '0;
        if (a_nan || b_nan || (a_zero && b_zero) || (a_inf && b_inf)) begin
            special_word = QNAN_W;
        end else if (a_inf || b_zero) begin
            special_word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (a_zero || b_inf) begin
            special_word = {sign, {(WORD_W-1){1'b0}}};
        end else begin
            special = 1'b0;
        end
    end

endmodule

// File: rtl/fpdiv_r16_core.sv
module fpdiv_r16_core #(
    parameter int SIG_W   = 24,
    parameter int EXT_W   = 24,
    parameter int RADIX_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [SIG_W+EXT_W-1:0]   dividend,
    input  logic [SIG_W-1:0]         divisor,
    output logic                     fin,
    output logic [SIG_W+EXT_W-1:0]   quot
);

    localparam int Q_W    = SIG_W + EXT_W;
    localparam int DIGITS = Q_W / RADIX_W;
    localparam int REM_W  = SIG_W + RADIX_W;
    localparam int NMULT  = (1 << RADIX_W) - 1;
    localparam int CNT_W  = $clog2(DIGITS + 1);

    logic               busy_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [REM_W-1:0]   rem_q;
    logic [Q_W-1:0]     dvd_q;
    logic [SIG_W-1:0]   dsr_q;
    logic [Q_W-1:0]     quot_q;

    logic [REM_W-1:0]   part;
    logic [REM_W:0]     diff [1:NMULT];
    logic [REM_W-1:0]   rem_next;
    logic [RADIX_W-1:0] digit;

    // remainder stays below the divisor, so the top bits are always zero
    assign part = REM_W'({rem_q, dvd_q[Q_W-1 -: RADIX_W]});

    for (genvar j = 1; j <= NMULT; j++) begin : g_mult
        assign diff[j] = {1'b0, part} - {1'b0, REM_W'(dsr_q) * REM_W'(j)};
    end

    always_comb begin
        digit    = '0;
        rem_next = part;
        for (int k = 1; k <= NMULT; k++) begin
            if (!diff[k][REM_W]) begin
                digit    = RADIX_W'(k);
                rem_next = diff[k][REM_W-1:0];
            end
        end
    end

    assign fin  = busy_q && (cnt_q == CNT_W'(DIGITS - 1));
    assign quot = quot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            dvd_q  <= '0;
            dsr_q  <= '0;
            quot_q <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            rem_q  <= '0;
            dvd_q  <= dividend;
            dsr_q  <= divisor;
            quot_q <= '0;
        end else if (busy_q) begin
            rem_q  <= rem_next;
            dvd_q  <= dvd_q << RADIX_W;
            quot_q <= (quot_q << RADIX_W) | Q_W'(digit);
            cnt_q  <= cnt_q + 1'b1;
            if (fin) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fpdiv_pack.sv
module fpdiv_pack
    import fpdiv_pkg::*;
(
    input  logic                     sign,
    input  logic signed [EXPI_W-1:0] exp_a,
    input  logic signed [EXPI_W-1:0] exp_b,
    input  logic [Q_W-1:0]           quot,
    output logic [WORD_W-1:0]        word
);

    localparam int LEAD_W = $clog2(Q_W);

    logic [LEAD_W-1:0]          lead;
    logic [LEAD_W-1:0]          shamt;
    logic signed [EXPI_W-1:0]   lead_s;
    logic signed [EXPI_W-1:0]   biased;
    logic [FRAC_W-1:0]          frac;

    always_comb begin
        lead = '0;
        for (int i = 0; i < Q_W; i++) begin
            if (quot[i]) begin
                lead = LEAD_W'(i);
            end
        end
    end

    // a quotient of exactly 1.0 has its leading one at position EXT_W
    assign lead_s = $signed(EXPI_W'(lead));
    assign biased = exp_a - exp_b + BIAS_S + lead_s - EXPI_W'(EXT_W);
    assign shamt  = lead - LEAD_W'(FRAC_W);
    assign frac   = FRAC_W'(quot >> shamt);

    always_comb begin
        if (biased >= EXP_TOP_S) begin
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (biased <= EXPI_W'(0)) begin
            word = {sign, {(WORD_W-1){1'b0}}};
        end else begin
            word = {sign, EXP_W'(biased), frac};
        end
    end

endmodule

// File: rtl/fp_div_sp.sv
module fp_div_sp
    import fpdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    output logic        done,
    output logic [31:0] result
);

    fsm_t state_q, state_d;

    logic                     u_sign, u_special;
    logic signed [EXPI_W-1:0] u_exp_a, u_exp_b;
    logic [SIG_W-1:0]         u_sig_a, u_sig_b;
    logic [WORD_W-1:0]        u_special_word;

    logic                     sign_q, spec_q;
    logic signed [EXPI_W-1:0] exp_a_q, exp_b_q;
    logic [SIG_W-1:0]         sig_a_q, sig_b_q;
    logic [WORD_W-1:0]        spec_word_q;

    logic                     core_load, core_fin;
    logic [Q_W-1:0]           core_quot;
    logic [WORD_W-1:0]        packed_word;
    logic                     done_q;
    logic [WORD_W-1:0]        result_q;

    fpdiv_unpack u_unpack (
        .a            (op_a),
        .b            (op_b),
        .sign         (u_sign),
        .exp_a        (u_exp_a),
        .exp_b        (u_exp_b),
        .sig_a        (u_sig_a),
        .sig_b        (u_sig_b),
        .special      (u_special),
        .special_word (u_special_word)
    );

    assign core_load = (state_q == S_NORM) && sig_a_q[SIG_W-1];

    fpdiv_r16_core #(
        .SIG_W   (SIG_W),
        .EXT_W   (EXT_W),
        .RADIX_W (RADIX_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (core_load),
        .dividend ({sig_a_q, {EXT_W{1'b0}}}),
        .divisor  (sig_b_q),
        .fin      (core_fin),
        .quot     (core_quot)
    );

    fpdiv_pack u_pack (
        .sign  (sign_q),
        .exp_a (exp_a_q),
        .exp_b (exp_b_q),
        .quot  (core_quot),
        .word  (packed_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = u_special ? S_PACK : S_NORM;
            S_NORM: if (sig_a_q[SIG_W-1]) state_d = S_DIV;
            S_DIV:  if (core_fin) state_d = S_PACK;
            S_PACK: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // operand capture and dividend normalisation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sign_q      <= 1'b0;
            spec_q      <= 1'b0;
            exp_a_q     <= '0;
            exp_b_q     <= '0;
            sig_a_q     <= '0;
            sig_b_q     <= '0;
            spec_word_q <= '0;
        end else begin
            if (state_q == S_IDLE && start) begin
                sign_q      <= u_sign;
                spec_q      <= u_special;
                exp_a_q     <= u_exp_a;
                exp_b_q     <= u_exp_b;
                sig_a_q     <= u_sig_a;
                sig_b_q     <= u_sig_b;
                spec_word_q <= u_special_word;
            end else if (state_q == S_NORM && !sig_a_q[SIG_W-1]) begin
                sig_a_q <= sig_a_q << 1;
                exp_a_q <= exp_a_q - EXPI_W'(1);
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= (state_q == S_PACK);
            if (state_q == S_PACK) begin
                result_q <= spec_q ? spec_word_q : packed_word;
            end
        end
    end

    assign done   = done_q;
    assign result = result_q;

endmodule

// File: rtl/fp_div_sp_chk.sv
module fp_div_sp_chk
    import fpdiv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic [31:0]      result,
    input fsm_t             state,
    input logic [SIG_W-1:0] sig_a
);

    // R12: done never lasts two cycles
    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: leaving the packing state always produces done
    p_pack_gives_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PACK) |=> done);

    // R9: every NaN the block emits is the canonical quiet NaN
    p_nan_canonical_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[30:23] == 8'hFF && result[22:0] != 23'd0) |-> (result == QNAN_W));

    // R8: no subnormal ever leaves the block
    p_no_subnormal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(result[30:23] == 8'h00 && result[22:0] != 23'd0));

    // R4: one left shift per cycle while the top bit is clear
    p_norm_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_NORM && !sig_a[SIG_W-1]) |=> (sig_a == ($past(sig_a) << 1)));

    // R13: a running division is never abandoned
    p_div_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DIV) |=> (state == S_DIV || state == S_PACK));

endmodule

bind fp_div_sp fp_div_sp_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done),
    .result (result),
    .state  (state_q),
    .sig_a  (sig_a_q)
);

// File: tb/fp_div_sp_bench.sv
module fp_div_sp_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        done;
    logic [31:0] result;

    int n_checks = 0;
    int n_errors = 0;

    fp_div_sp u_fp_div_sp (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op_a   (op_a),
        .op_b   (op_b),
        .done   (done),
        .result (result)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one division; latency counts rising edges from the start-sampling edge
    task automatic run_div(input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] exp_res, input int exp_lat,
                           input string tag);
        int  lat = 0;
        bit  got = 0;
        @(negedge clk);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        while (!got && lat < 200) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (done) got = 1;
        end
        check(got && result == exp_res, tag, result, exp_res);
        check(lat == exp_lat, {tag, " R12 latency"}, 32'(lat), 32'(exp_lat));
        @(negedge clk);
        check(!done, "R12 done single cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset;
        check(done == 1'b0, "R12 reset done", {31'd0, done}, 32'd0);
        check(result == 32'd0, "R12 reset result", result, 32'd0);
    endtask

    task automatic t_normal;
        run_div(32'h40C00000, 32'h40000000, 32'h40400000, 15, "R1 6/2");
        run_div(32'hC0F00000, 32'h40200000, 32'hC0400000, 15, "R2 -7.5/2.5");
        run_div(32'h3F800000, 32'hBF800000, 32'hBF800000, 15, "R2 1/-1");
        run_div(32'h3F800000, 32'h3FC00000, 32'h3F2AAAAA, 15, "R3 1/1.5");
        run_div(32'h3F800000, 32'h40400000, 32'h3EAAAAAA, 15, "R6 1/3");
    endtask

    task automatic t_denormal;
        run_div(32'h00400000, 32'h3A800000, 32'h05000000, 16, "R4 sub/2^-10");
        run_div(32'h3F800000, 32'h00400000, 32'h7F000000, 15, "R5 1/sub");
    endtask

    task automatic t_range;
        run_div(32'h7F000000, 32'h3E800000, 32'h7F800000, 15, "R7 overflow");
        run_div(32'h00800000, 32'h40800000, 32'h00000000, 15, "R8 underflow");
        run_div(32'h80800000, 32'h40800000, 32'h80000000, 15, "R8 neg underflow");
    endtask

    task automatic t_special;
        run_div(32'h00000000, 32'h00000000, 32'h7FC00000, 2, "R9 0/0");
        run_div(32'h7F800000, 32'hFF800000, 32'h7FC00000, 2, "R9 inf/inf");
        run_div(32'h7FC00001, 32'h3F800000, 32'h7FC00000, 2, "R9 nan in");
        run_div(32'hBF800000, 32'h00000000, 32'hFF800000, 2, "R10 -1/0");
        run_div(32'h7F800000, 32'h40000000, 32'h7F800000, 2, "R10 inf/2");
        run_div(32'h00000000, 32'h40A00000, 32'h00000000, 2, "R11 0/5");
        run_div(32'hC0A00000, 32'h7F800000, 32'h80000000, 2, "R11 -5/inf");
    endtask

    // second start while busy must not disturb the running division
    task automatic t_busy_start;
        int  lat = 0;
        bit  got = 0;
        @(negedge clk);
        op_a  = 32'h40C00000;
        op_b  = 32'h40000000;
        start = 1'b1;
        while (!got && lat < 200) begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            if (lat == 5) begin
                op_a  = 32'h3F800000;
                op_b  = 32'h00000000;
                start = 1'b1;
            end
            if (done) got = 1;
        end
        check(got && result == 32'h40400000, "R13 busy start result", result, 32'h40400000);
        check(lat == 15, "R13 busy start latency", 32'(lat), 32'd15);
        @(negedge clk);
        check(!done, "R13 no extra done", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_denormal();
        t_range();
        t_special();
        t_busy_start();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog R12 actual=%h expected=%h", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule